// File: doc/BRIEF.md
# Peripheral Clock Divider with Fractional Mode

This block runs on the fast system clock and produces a slower timing signal for peripheral logic. The divisor is programmable. It can be an 8-bit integer or a 16-bit integer. A 16-bit integer can also carry a 5-bit fraction, which in 32nds sets the average output frequency more finely. The register value is the divisor minus one. The divisor N is therefore the programmed value plus one, and a value of zero means divide by one.

The output style is selectable. In pulse style, `clk_en` goes high for one source cycle at the start of every output period, so downstream registers can use it as a clock enable. In clock style, `clk_out` is a divided clock: high in the first part of each period and low in the rest. Even periods give equal halves. Odd periods give one extra high cycle.

A two-state machine controls the counter. From `ST_IDLE`, the *start* transition (taken when `en` is sampled high) moves to `ST_RUN` and loads the first period. In `ST_RUN`, the *count* transition advances the period counter. The *wrap* transition, taken on the last cycle of a period, loads the next period from the current inputs and steps the fraction accumulator. The *stop* transition returns to `ST_IDLE` whenever `en` is sampled low, from either state. It clears the counter, the stored period and the accumulator.

Top module: `pclkdiv`

## Requirements
- R1: While `rst_n` is low, and in `ST_IDLE`, both `clk_en` and `clk_out` are low.
- R2: When `en` is sampled low at a rising edge, both outputs are low after that edge. A later enable starts again with a cleared fraction accumulator.
- R3: In pulse style (`out_mode`=0), `clk_en` is high for exactly one cycle at the start of each period, with N cycles from one pulse to the next, and `clk_out` stays low. In clock style (`out_mode`=1), `clk_en` stays low.
- R4: `kind`=2'b00 uses only `div_val[7:0]` (upper bits ignored). `kind`=2'b01 and 2'b11 use all 16 bits of `div_val`. `kind`=2'b10 uses 16 bits plus the fraction.
- R5: In clock style with an even period length L, `clk_out` is high for L/2 cycles and then low for L/2 cycles.
- R6: In clock style with an odd period length L greater than one, `clk_out` is high for (L+1)/2 cycles and low for (L-1)/2 cycles.
- R7: A programmed value of 0 (divide by one) holds `clk_en` high in pulse style. In clock style, `clk_out` follows the source clock.
- R8: With `kind`=2'b10 and fraction F (0..31), period k (counting from 1 after enable) lasts N+1 cycles when floor(k·F/32) > floor((k−1)·F/32), and N cycles otherwise. With any other `kind`, `frac_val` has no effect.
- R9: A change of `div_val` during a period does not alter that period. The new value sets the length of the next period.
- R10: The first period starts in the cycle after the edge that samples `en` high: `clk_en` (pulse style) or `clk_out` (clock style, L>1) is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Divider run enable, synchronous |
| kind | input | 2 | Divisor kind: 00 8-bit, 01/11 16-bit, 10 16-bit with fraction |
| out_mode | input | 1 | 0 pulse style, 1 clock style |
| div_val | input | 16 | Divisor minus one |
| frac_val | input | 5 | Fraction in 32nds, used only with kind 10 |
| clk_en | output | 1 | One-cycle enable pulse per period |
| clk_out | output | 1 | Divided clock |

## Verification
The assertions assume that `en` and the divisor inputs are synchronous to `clk`. They also assume that `out_mode` is steady while the divider runs, because a mid-period style change truncates a phase by design. The bench changes every input only on falling edges. It sets the style before each enable and returns `en` low before it reprograms `out_mode`. The bench does change the divisor in the middle of a period, and the period-holding property covers exactly that case.

// File: rtl/pclkdiv_pkg.sv
package pclkdiv_pkg;

    typedef enum logic [1:0] {
        KIND_NARROW = 2'b00,
        KIND_WIDE   = 2'b01,
        KIND_FRAC   = 2'b10,
        KIND_WIDE2  = 2'b11
    } div_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

    typedef enum logic {
        OUT_PULSE = 1'b0,
        OUT_CLOCK = 1'b1
    } out_mode_e;

endpackage

// File: rtl/pclkdiv_period_calc.sv
module pclkdiv_period_calc
    import pclkdiv_pkg::*;
#(
    parameter int INT_W    = 16,
    parameter int NARROW_W = 8,
    parameter int FRAC_W   = 5
) (
    input  div_kind_e         kind,
    input  logic [INT_W-1:0]  div_val,
    input  logic [FRAC_W-1:0] frac_val,
    input  logic [FRAC_W-1:0] acc_q,
    output logic [INT_W:0]    next_last,
    output logic [FRAC_W-1:0] next_acc
);
    localparam int SUM_W = FRAC_W + 1;

    logic [INT_W-1:0]  narrow_base;
    logic [INT_W-1:0]  base;
    logic [FRAC_W-1:0] frac_add;
    logic [SUM_W-1:0]  sum;

    // Narrow divisor: zero-extend the low field when it is shorter than the full width.
    generate
        if (NARROW_W < INT_W) begin : g_narrow_ext
            assign narrow_base = {{(INT_W-NARROW_W){1'b0}}, div_val[NARROW_W-1:0]};
        end else begin : g_narrow_full
            assign narrow_base = div_val;
        end
    endgenerate

    always_comb begin
        unique case (kind)
            KIND_NARROW: begin
                base     = narrow_base;
                frac_add = '0;
            end
            KIND_FRAC: begin
                base     = div_val;
                frac_add = frac_val;
            end
            KIND_WIDE, KIND_WIDE2: begin
                base     = div_val;
                frac_add = '0;
            end
            default: begin
                base     = div_val;
                frac_add = '0;
            end
        endcase
        sum       = {1'b0, acc_q} + {1'b0, frac_add};
        next_acc  = sum[FRAC_W-1:0];
        next_last = {1'b0, base} + {{INT_W{1'b0}}, sum[FRAC_W]};
    end

endmodule

// File: rtl/pclkdiv_fsm.sv
module pclkdiv_fsm
    import pclkdiv_pkg::*;
#(
    parameter int CNT_W  = 17,
    parameter int FRAC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CNT_W-1:0]  next_last,
    input  logic [FRAC_W-1:0] next_acc,
    output div_state_e        state_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  last_q,
    output logic [FRAC_W-1:0] acc_q
);
    div_state_e state_d;
    logic       load;

    // Next-state selection: start, count, wrap, stop.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = en ? ST_RUN : ST_IDLE;
            ST_RUN:  state_d = en ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign load = en && ((state_q == ST_IDLE) || (cnt_q == last_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
            acc_q  <= '0;
        end else if (!en) begin
            cnt_q  <= '0;
            last_q <= '0;
            acc_q  <= '0;
        end else if (load) begin
            cnt_q  <= '0;
            last_q <= next_last;
            acc_q  <= next_acc;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pclkdiv_outputs.sv
module pclkdiv_outputs
    import pclkdiv_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  div_state_e       state_q,
    input  out_mode_e        out_mode,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] last_q,
    output logic             clk_en,
    output logic             clk_out
);
    localparam int HI_W = CNT_W + 1;

    logic [HI_W-1:0] hi_len;
    logic            bypass;
    logic            high_phase;

    assign hi_len     = ({1'b0, last_q} + HI_W'(2)) >> 1;
    assign bypass     = (last_q == '0);
    assign high_phase = ({1'b0, cnt_q} < hi_len);

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                clk_en  = 1'b0;
                clk_out = 1'b0;
            end
            ST_RUN: begin
                if (out_mode == OUT_PULSE) begin
                    clk_en  = (cnt_q == '0);
                    clk_out = 1'b0;
                end else begin
                    clk_en  = 1'b0;
                    clk_out = bypass ? clk : high_phase;
                end
            end
            default: begin
                clk_en  = 1'b0;
                clk_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pclkdiv.sv
module pclkdiv
    import pclkdiv_pkg::*;
#(
    parameter int INT_W    = 16,
    parameter int NARROW_W = 8,
    parameter int FRAC_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        kind,
    input  logic              out_mode,
    input  logic [INT_W-1:0]  div_val,
    input  logic [FRAC_W-1:0] frac_val,
    output logic              clk_en,
    output logic              clk_out
);
    localparam int CNT_W = INT_W + 1;

    div_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_q;
    logic [FRAC_W-1:0] acc_q;
    logic [CNT_W-1:0]  next_last;
    logic [FRAC_W-1:0] next_acc;

    pclkdiv_period_calc #(
        .INT_W    (INT_W),
        .NARROW_W (NARROW_W),
        .FRAC_W   (FRAC_W)
    ) u_calc (
        .kind      (div_kind_e'(kind)),
        .div_val   (div_val),
        .frac_val  (frac_val),
        .acc_q     (acc_q),
        .next_last (next_last),
        .next_acc  (next_acc)
    );

    pclkdiv_fsm #(
        .CNT_W  (CNT_W),
        .FRAC_W (FRAC_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .next_last (next_last),
        .next_acc  (next_acc),
        .state_q   (state_q),
        .cnt_q     (cnt_q),
        .last_q    (last_q),
        .acc_q     (acc_q)
    );

    pclkdiv_outputs #(
        .CNT_W (CNT_W)
    ) u_out (
        .clk      (clk),
        .state_q  (state_q),
        .out_mode (out_mode_e'(out_mode)),
        .cnt_q    (cnt_q),
        .last_q   (last_q),
        .clk_en   (clk_en),
        .clk_out  (clk_out)
    );

endmodule

// File: rtl/pclkdiv_chk.sv
module pclkdiv_chk
    import pclkdiv_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             out_mode,
    input div_state_e       state_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] last_q,
    input logic             clk_en
);

    // R1: the idle state never raises the enable pulse
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !clk_en);

    // R2: a low enable returns to idle with the pulse low
    a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == ST_IDLE && !clk_en));

    // R3: the counter never runs past the stored period end
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q <= last_q));

    // R3: for periods longer than one cycle the pulse lasts one cycle
    a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && last_q != '0) |=> !clk_en);

    // R7: divide-by-one in pulse style holds the enable high
    a_r7_bypass_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && last_q == '0 && out_mode == 1'b0) |-> clk_en);

    // R9: the stored period is held until its final cycle
    a_r9_period_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && en && cnt_q != last_q) |=> $stable(last_q));

    // R10: start loads a fresh period at count zero
    a_r10_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && en) |=> (state_q == ST_RUN && cnt_q == '0));

endmodule

bind pclkdiv pclkdiv_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .out_mode (out_mode),
    .state_q  (state_q),
    .cnt_q    (cnt_q),
    .last_q   (last_q),
    .clk_en   (clk_en)
);

// File: tb/pclkdiv_bench.sv
module pclkdiv_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  kind = 2'b01;
    logic        out_mode = 1'b0;
    logic [15:0] div_val = '0;
    logic [4:0]  frac_val = '0;
    logic        clk_en;
    logic        clk_out;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pclkdiv u_pclkdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .kind     (kind),
        .out_mode (out_mode),
        .div_val  (div_val),
        .frac_val (frac_val),
        .clk_en   (clk_en),
        .clk_out  (clk_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Check one period of length len against the pulse or clock pattern.
    task automatic check_period(input int len, input string req);
        for (int p = 0; p < len; p++) begin
            @(negedge clk); #1;
            if (out_mode == 1'b0) begin
                chk(req, clk_en, (p == 0));
                chk(req, clk_out, 1'b0);
            end else begin
                chk(req, clk_en, 1'b0);
                chk(req, clk_out, (p < (len + 1) / 2));
            end
        end
    endtask

    task automatic stop_and_check(input string req);
        en = 1'b0;
        @(negedge clk); #1;
        chk(req, clk_en, 1'b0);
        chk(req, clk_out, 1'b0);
    endtask

    task automatic run_cfg(input logic [1:0] k, input logic m, input logic [15:0] d,
                           input logic [4:0] f, input int nper, input string req);
        int n;
        int c;
        @(negedge clk);
        kind = k; out_mode = m; div_val = d; frac_val = f; en = 1'b1;
        n = (k == 2'b00) ? int'(d[7:0]) + 1 : int'(d) + 1;
        for (int kk = 1; kk <= nper; kk++) begin
            c = (k == 2'b10) ? ((kk * int'(f)) / 32 - ((kk - 1) * int'(f)) / 32) : 0;
            check_period(n + c, req);
        end
        @(negedge clk);
        stop_and_check("R2");
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : stim
        // R1: outputs quiet during reset even with enable requested
        en = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", clk_en, 1'b0);
        chk("R1", clk_out, 1'b0);
        en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", clk_en, 1'b0);
        chk("R1", clk_out, 1'b0);

        // R3 R10: pulse style, wide divisor sweep including divide by one (R7)
        for (int d = 0; d <= 20; d++) begin
            run_cfg(2'b01, 1'b0, 16'(d), 5'd0, 3, (d == 0) ? "R7" : "R3");
        end
        // R5 R6: clock style sweep
        for (int d = 1; d <= 20; d++) begin
            run_cfg(2'b01, 1'b1, 16'(d), 5'd0, 3, (d % 2 == 1) ? "R5" : "R6");
        end
        // R4: narrow kind ignores the upper byte; kind 11 acts as wide
        run_cfg(2'b00, 1'b0, 16'hFF03, 5'd0, 3, "R4");
        run_cfg(2'b00, 1'b1, 16'h1207, 5'd0, 3, "R4");
        run_cfg(2'b00, 1'b0, 16'hA5FF, 5'd0, 2, "R4");
        run_cfg(2'b11, 1'b1, 16'd6, 5'd0, 3, "R4");
        // R8: fraction ignored outside the fractional kind
        run_cfg(2'b01, 1'b0, 16'd3, 5'd17, 4, "R8");
        run_cfg(2'b00, 1'b1, 16'd3, 5'd31, 4, "R8");
        // R8: fractional sweep over every fraction
        for (int m = 0; m < 2; m++) begin
            for (int d = 1; d <= 4; d++) begin
                for (int f = 0; f < 32; f++) begin
                    run_cfg(2'b10, 1'(m), 16'(d), 5'(f), 32, "R8");
                end
            end
        end

        // R7: clock style divide by one follows the source clock
        @(negedge clk);
        kind = 2'b01; out_mode = 1'b1; div_val = 16'd0; en = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #2;
            chk("R7", clk_out, 1'b1);
            chk("R7", clk_en, 1'b0);
            @(negedge clk); #1;
            chk("R7", clk_out, 1'b0);
        end
        stop_and_check("R2");

        // R9: divisor change mid-period applies at the next period
        @(negedge clk);
        kind = 2'b01; out_mode = 1'b0; div_val = 16'd5; en = 1'b1;
        for (int p = 0; p < 3; p++) begin
            @(negedge clk); #1;
            chk("R9", clk_en, (p == 0));
        end
        div_val = 16'd2;
        for (int p = 3; p < 6; p++) begin
            @(negedge clk); #1;
            chk("R9", clk_en, 1'b0);
        end
        check_period(3, "R9");
        check_period(3, "R9");
        stop_and_check("R2");

        // R2: mid-period disable, then restart with a cleared accumulator
        @(negedge clk);
        kind = 2'b10; out_mode = 1'b1; div_val = 16'd2; frac_val = 5'd20; en = 1'b1;
        repeat (7) @(negedge clk);
        stop_and_check("R2");
        run_cfg(2'b10, 1'b1, 16'd2, 5'd20, 8, "R2");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule